// File: doc/BRIEF.md
# Vertical Sync Divider with Reset Windows

This block generates vertical timing for a 50 Hz or 60 Hz raster. It runs on a clock at twice the horizontal line rate and takes the separated vertical sync pulse from the sync separator. A free-running divider count marks the position within the field. A sync pulse restarts the divider only when that count lies inside the current reset window. If no pulse arrives in time, the divider restarts itself at the last count of the window. The count at which a pulse is accepted sets the field standard.

Every sync event moves a saturating 0..15 confidence counter up or down. The counter chooses between a wide search window that covers both standards and a narrow lock window around the expected field length. The block produces a one-cycle field-start strobe for the ramp generator, a standard flag, a lock-window status, and a gating pulse. The gating pulse blanks the line phase detector around the vertical sync interval.

Top module: `vert_sync_divider`

## Requirements
- R1: While reset is active and in the first cycle after release, fieldStart is 0, is60Hz is 0 (50 Hz assumed), lockWin is 0 (search window), and atfGate is 1, because the count is 0.
- R2: The sync input passes through a two-flop synchronizer and is edge-detected, so a pulse of any length is one event. An accepted event seen at count c raises fieldStart for exactly one cycle, and that field lasts c+1 clock cycles (counts 0..c).
- R3: In search mode the window is counts 488 to 628 inclusive. A sync event at any other count does not restart the divider.
- R4: When no event is accepted, the divider restarts itself after the last count of the active window. A search-mode field therefore lasts 629 cycles, and a lock-mode field lasts one cycle more than the window's upper limit.
- R5: An accepted event at a count below 576 sets is60Hz to 1, and one at 576 or above sets it to 0. A self-restart leaves is60Hz unchanged.
- R6: The confidence counter rises by 1 on every accepted event and falls by 1 on every rejected event and on every self-restart. It saturates at 0 and 15. Lock mode is entered when an accepted event brings the counter to 15.
- R7: In lock mode the window is counts 522..528 when is60Hz is 1 and counts 622..628 when is60Hz is 0.
- R8: The block returns to search mode as soon as the confidence counter falls below 10.
- R9: atfGate is high from every divider restart through count 11 when is60Hz is 1, and through count 9 when is60Hz is 0. In lock mode it also goes high at the lower window limit of the current standard.
- R10: An accepted event in search mode whose count lies outside both lock windows (522..528 and 622..628) does not enter lock mode, even with the counter at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider clock, twice the line rate |
| rstN | input | 1 | Asynchronous active-low reset |
| vSyncIn | input | 1 | Separated vertical sync, asynchronous, active high |
| fieldStart | output | 1 | One-cycle strobe at each divider restart |
| is60Hz | output | 1 | 1 = 60 Hz standard detected, 0 = 50 Hz |
| lockWin | output | 1 | 1 = narrow lock window active, 0 = search window |
| atfGate | output | 1 | Anti-top-flutter gate for the line phase detector |

## Verification
A divider count that has gone wrong shows up within one field, as a field length between fieldStart strobes that differs from the count at which the pulse was sent plus one. A confidence counter that misses saturation or steps the wrong way does not show at once. It shows some fields later, when lockWin changes on a different field than a count of accepted and rejected events predicts. A wrong standard flag changes the length of the atfGate pulse at the start of the next field and, in lock mode, the count at which atfGate rises again.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  // strobes from window control to the divider datapath
  typedef struct packed {
    logic restart;  // clear divider, emit field start
    logic accept;   // restart caused by an in-window sync event
  } divStrobe_t;
endpackage

// File: rtl/vsd_datapath.sv
module vsd_datapath
  import vsd_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int CNT_LIMIT  = 628,
  parameter int SYNC_DEPTH = 2,
  parameter int ATF_END50  = 10,
  parameter int ATF_END60  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vSyncIn,
  input  divStrobe_t       st,
  input  logic             is60Hz,
  input  logic             lockWin,
  input  logic [CNT_W-1:0] atfStart,
  output logic             syncEdge,
  output logic [CNT_W-1:0] cnt,
  output logic             fieldStart,
  output logic             atfGate
);
  localparam logic [CNT_W-1:0] END50 = CNT_W'(ATF_END50);
  localparam logic [CNT_W-1:0] END60 = CNT_W'(ATF_END60);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_LIMIT);

  // synchronizer chain plus one delay stage for edge detection
  logic [SYNC_DEPTH:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_DEPTH-1:0], vSyncIn};
  end

  assign syncEdge = syncQ[SYNC_DEPTH-1] & ~syncQ[SYNC_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      fieldStart <= 1'b0;
    end else begin
      cnt        <= st.restart ? '0 : cnt + 1'b1;
      fieldStart <= st.restart;
    end
  end

  logic [CNT_W-1:0] atfEnd;
  assign atfEnd  = is60Hz ? END60 : END50;
  assign atfGate = (cnt < atfEnd) || (lockWin && (cnt >= atfStart));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LIMIT);

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |=> !fieldStart);

  // R2
  start_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |-> (cnt == '0));
endmodule

// File: rtl/vsd_control.sv
module vsd_control
  import vsd_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int SRCH_LO   = 488,
  parameter int SRCH_HI   = 628,
  parameter int STD_SPLIT = 576,
  parameter int L60_LO    = 522,
  parameter int L60_HI    = 528,
  parameter int L50_LO    = 622,
  parameter int L50_HI    = 628,
  parameter int CONF_W    = 4,
  parameter int CONF_DROP = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncEdge,
  input  logic [CNT_W-1:0] cnt,
  output divStrobe_t       st,
  output logic             is60Hz,
  output logic             lockWin,
  output logic [CNT_W-1:0] atfStart
);
  localparam logic [CNT_W-1:0]  S_LO  = CNT_W'(SRCH_LO);
  localparam logic [CNT_W-1:0]  S_HI  = CNT_W'(SRCH_HI);
  localparam logic [CNT_W-1:0]  SPLIT = CNT_W'(STD_SPLIT);
  localparam logic [CNT_W-1:0]  A_LO  = CNT_W'(L60_LO);
  localparam logic [CNT_W-1:0]  A_HI  = CNT_W'(L60_HI);
  localparam logic [CNT_W-1:0]  B_LO  = CNT_W'(L50_LO);
  localparam logic [CNT_W-1:0]  B_HI  = CNT_W'(L50_HI);
  localparam logic [CONF_W-1:0] C_MAX = {CONF_W{1'b1}};
  localparam logic [CONF_W-1:0] C_LOW = CONF_W'(CONF_DROP);

  logic [CONF_W-1:0] conf, confNext;
  logic [CNT_W-1:0]  winLo, winHi;
  logic inWin, accept, reject, endMiss, pulse60, inLockSpan, lockNext;

  always_comb begin
    if (lockWin) begin
      winLo = is60Hz ? A_LO : B_LO;
      winHi = is60Hz ? A_HI : B_HI;
    end else begin
      winLo = S_LO;
      winHi = S_HI;
    end
  end

  assign inWin      = (cnt >= winLo) && (cnt <= winHi);
  assign accept     = syncEdge && inWin;
  assign reject     = syncEdge && !inWin;
  assign endMiss    = !accept && (cnt == winHi);
  assign pulse60    = cnt < SPLIT;
  assign inLockSpan = pulse60 ? ((cnt >= A_LO) && (cnt <= A_HI))
                              : ((cnt >= B_LO) && (cnt <= B_HI));
  assign atfStart   = is60Hz ? A_LO : B_LO;

  always_comb begin
    st.restart = accept || endMiss;
    st.accept  = accept;
  end

  always_comb begin
    confNext = conf;
    if (accept) begin
      if (conf != C_MAX) confNext = conf + 1'b1;
    end else if (reject || endMiss) begin
      if (conf != '0) confNext = conf - 1'b1;
    end
  end

  always_comb begin
    lockNext = lockWin;
    if (accept && (confNext == C_MAX) && inLockSpan) lockNext = 1'b1;
    else if (confNext < C_LOW)                        lockNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      conf    <= '0;
      lockWin <= 1'b0;
      is60Hz  <= 1'b0;
    end else begin
      conf    <= confNext;
      lockWin <= lockNext;
      if (accept) is60Hz <= pulse60;
    end
  end

  // R6
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockWin) |-> $past(st.accept));

  // R10
  lock_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockWin) |-> ((($past(cnt) >= A_LO) && ($past(cnt) <= A_HI)) ||
                        (($past(cnt) >= B_LO) && ($past(cnt) <= B_HI))));

  // R8
  lock_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockWin) |-> ($past(syncEdge) || $past(st.restart)));

  // R5
  std_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (is60Hz != $past(is60Hz)) |-> $past(st.accept));
endmodule

// File: rtl/vert_sync_divider.sv
module vert_sync_divider
  import vsd_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int SYNC_DEPTH = 2,
  parameter int SRCH_LO    = 488,
  parameter int SRCH_HI    = 628,
  parameter int STD_SPLIT  = 576,
  parameter int L60_LO     = 522,
  parameter int L60_HI     = 528,
  parameter int L50_LO     = 622,
  parameter int L50_HI     = 628,
  parameter int CONF_W     = 4,
  parameter int CONF_DROP  = 10,
  parameter int ATF_END50  = 10,
  parameter int ATF_END60  = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic vSyncIn,
  output logic fieldStart,
  output logic is60Hz,
  output logic lockWin,
  output logic atfGate
);
  localparam int CNT_LIMIT = (SRCH_HI > L50_HI) ? SRCH_HI : L50_HI;

  divStrobe_t       st;
  logic             syncEdge;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] atfStart;

  vsd_control #(
    .CNT_W(CNT_W), .SRCH_LO(SRCH_LO), .SRCH_HI(SRCH_HI), .STD_SPLIT(STD_SPLIT),
    .L60_LO(L60_LO), .L60_HI(L60_HI), .L50_LO(L50_LO), .L50_HI(L50_HI),
    .CONF_W(CONF_W), .CONF_DROP(CONF_DROP)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .syncEdge(syncEdge), .cnt(cnt), .st(st),
    .is60Hz(is60Hz), .lockWin(lockWin), .atfStart(atfStart)
  );

  vsd_datapath #(
    .CNT_W(CNT_W), .CNT_LIMIT(CNT_LIMIT), .SYNC_DEPTH(SYNC_DEPTH),
    .ATF_END50(ATF_END50), .ATF_END60(ATF_END60)
  ) dp_i (
    .clk(clk), .rstN(rstN), .vSyncIn(vSyncIn), .st(st), .is60Hz(is60Hz),
    .lockWin(lockWin), .atfStart(atfStart), .syncEdge(syncEdge), .cnt(cnt),
    .fieldStart(fieldStart), .atfGate(atfGate)
  );
endmodule

// File: tb/vert_sync_divider_tb_top.sv
module vert_sync_divider_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vSyncIn = 1'b0;
  logic fieldStart, is60Hz, lockWin, atfGate;

  int nChecks = 0;
  int nFails  = 0;

  // bench model, built from the requirements
  bit expIs60 = 1'b0;
  bit expLock = 1'b0;
  int expConf = 0;

  always #4 clk = ~clk;

  vert_sync_divider dut_i (
    .clk(clk), .rstN(rstN), .vSyncIn(vSyncIn),
    .fieldStart(fieldStart), .is60Hz(is60Hz), .lockWin(lockWin), .atfGate(atfGate)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One field, starting at a negedge where the count is 0.
  // c < 0 sends no pulse; otherwise the event is seen at count c.
  task automatic runField(input int c, input string tag);
    int len = -1, atfLen = 0, rise = -1;
    bit atfRun = 1'b1;
    int lo, hi, expLen, expAtf, expRise;
    bit acc, p60, span;
    if (expLock) begin
      lo = expIs60 ? 522 : 622;
      hi = expIs60 ? 528 : 628;
    end else begin
      lo = 488;
      hi = 628;
    end
    expAtf  = expIs60 ? 12 : 10;
    expRise = expLock ? lo : -1;
    for (int n = 0; n < 2000; n++) begin
      if (n > 0 && fieldStart) begin
        len = n;
        break;
      end
      if (atfRun) begin
        if (atfGate) atfLen++;
        else atfRun = 1'b0;
      end else if (atfGate && rise < 0) begin
        rise = n;
      end
      if (c >= 2 && n == c - 2) vSyncIn = 1'b1;
      if (n == c) vSyncIn = 1'b0;
      @(negedge clk);
    end
    vSyncIn = 1'b0;
    acc = (c >= lo) && (c <= hi);
    if (acc) begin
      if (expConf < 15) expConf++;
      p60 = c < 576;
      expIs60 = p60;
      span = p60 ? (c >= 522 && c <= 528) : (c >= 622 && c <= 628);
      if (expConf == 15 && span) expLock = 1'b1;
      else if (expConf < 10) expLock = 1'b0;
      expLen = c + 1;
    end else begin
      if (c >= 0 && c < hi && expConf > 0) expConf--;
      if (expConf > 0) expConf--;
      if (expConf < 10) expLock = 1'b0;
      expLen = hi + 1;
    end
    chk(len == expLen, tag, "field length", len, expLen);
    chk(is60Hz == expIs60, "R5", "standard flag", int'(is60Hz), int'(expIs60));
    chk(lockWin == expLock, "R6/R8", "lock window", int'(lockWin), int'(expLock));
    chk(atfLen == expAtf, "R9", "atf length after restart", atfLen, expAtf);
    chk(rise == expRise, "R9", "atf rise count", rise, expRise);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(fieldStart == 1'b0, "R1", "fieldStart in reset", int'(fieldStart), 0);
    chk(is60Hz == 1'b0, "R1", "is60Hz in reset", int'(is60Hz), 0);
    chk(lockWin == 1'b0, "R1", "lockWin in reset", int'(lockWin), 0);
    rstN = 1'b1;
    chk(atfGate == 1'b1, "R1", "atfGate after reset", int'(atfGate), 1);
  endtask

  task automatic testFreeRun();
    // R4: no sync at all; the counter also stays saturated at 0
    runField(-1, "R4");
    runField(-1, "R4");
  endtask

  task automatic testSearchBounds();
    runField(487, "R3");  // below the search window: rejected
    runField(488, "R3");  // lowest accepted count, 60 Hz
    runField(576, "R5");  // first 50 Hz count
    runField(575, "R5");  // last 60 Hz count
  endtask

  task automatic testNoLockOffSpan();
    // R10: counter saturates at 15 while pulses miss both lock spans
    for (int i = 0; i < 15; i++) runField(500, "R10");
    chk(lockWin == 1'b0, "R10", "no lock off span", int'(lockWin), 0);
    runField(525, "R6");
    chk(lockWin == 1'b1, "R6", "lock after in-span pulse", int'(lockWin), 1);
  endtask

  task automatic testLock60();
    runField(525, "R7");
    runField(521, "R7");  // outside 522..528: free-run to 528
    runField(528, "R7");
    runField(522, "R7");
    runField(575, "R7");  // in search range but outside the lock window
  endtask

  task automatic testLockLoss();
    for (int i = 0; i < 6; i++) runField(-1, "R8");
    chk(lockWin == 1'b0, "R8", "lock lost after misses", int'(lockWin), 0);
    runField(-1, "R4");
  endtask

  task automatic testLock50();
    for (int i = 0; i < 16; i++) runField(625, "R6");
    chk(lockWin == 1'b1, "R6", "lock at 50 Hz", int'(lockWin), 1);
    runField(622, "R7");
    runField(628, "R7");
    runField(621, "R7");
    runField(525, "R7");  // 60 Hz count rejected in 50 Hz lock
    runField(-1, "R4");
  endtask

  initial begin
    testReset();
    testFreeRun();
    testSearchBounds();
    testNoLockOffSpan();
    testLock60();
    testLockLoss();
    testLock50();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #1500000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule